// File: doc/BRIEF.md
# Memory-Mapped PCI Configuration Decoder

This block sits between a simple CPU request port and a PCI configuration bus. CPU accesses that land in a 4 MiB memory window are turned into configuration cycles. Within that window, address bits 11 to 21 act as one-hot device select lines. The position of the lowest set line becomes the device number. The low eleven address bits carry the function number and the register offset unchanged.

A second, indirect path is decoded in I/O space. A 32-bit index register holds an enable bit, a bus number, a device, a function and a register. Accesses to a 4-byte data port are then forwarded as configuration cycles to the target that the index names.

Each accepted request produces at most one single-cycle configuration request. It then returns one single-cycle acknowledge carrying right-justified, little-endian read data. Absent devices read as all ones.

Top module: `cfg_window_bridge`

## Requirements
- R1: A memory-space access (cpu_io=0) is claimed only if its address lies in [0x8080_0000, 0x80C0_0000). An I/O access is claimed only at 0xCF8–0xCFB or 0xCFC–0xCFF. An unclaimed request produces neither cfg_req nor cpu_ack.
- R2: For a claimed window access, the device number is the index (0–10) of the lowest set bit among address bits 11–21. cfg_addr equals the device number shifted left by 11, ORed with address bits 10:0.
- R3: A window access with none of bits 11–21 set maps to device 11. Device 11 has no target, so no cfg_req is issued. A read returns all ones, masked to the access size, and a write is acknowledged with no effect.
- R4: cpu_size encodes 0 as 1 byte, 1 as 2 bytes, and 2 or 3 as 4 bytes. The lane offset is addr[1:0] for 1 byte, {addr[1],0} for 2 bytes and 0 for 4 bytes. cfg_be has the size's lanes set from that offset. Write data, taken right-justified, is shifted to the lane offset. Read data is shifted down by the offset and zero-extended above the size. cfg_we follows cpu_we. Writes acknowledge with cpu_rdata of 0.
- R5: When a forwarded read sees cfg_present low, cpu_rdata is all ones, masked to the access size. A forwarded write is issued whether or not a target is present.
- R6: The index register is written by a 4-byte I/O write to 0xCF8 and read back whole by a 4-byte I/O read there. Other sizes at 0xCF8 leave it unchanged and read as all ones, masked to the size.
- R7: A data-port access is forwarded only when index bit 31 is set and index bits 23:16 are zero. It then uses cfg_addr = {index[15:2], addr[1:0]}. Otherwise no cfg_req is issued, a read returns all ones and a write is dropped.
- R8: cfg_req is high for exactly the cycle after a forwarded request is accepted. cpu_ack is a one-cycle pulse two cycles after any claimed request. Requests may be issued on consecutive cycles.
- R9: During and after reset, cfg_req and cpu_ack are low and the index register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU request valid for one cycle |
| cpu_io | input | 1 | 1 = I/O space, 0 = memory space |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | CPU byte address |
| cpu_size | input | 2 | Access size code (0:1B, 1:2B, 2/3:4B) |
| cpu_wdata | input | 32 | Right-justified write data |
| cpu_ack | output | 1 | Completion pulse |
| cpu_rdata | output | 32 | Right-justified read data, valid with cpu_ack |
| cfg_req | output | 1 | Configuration cycle request |
| cfg_we | output | 1 | Configuration cycle is a write |
| cfg_addr | output | 16 | Bus-local configuration address |
| cfg_be | output | 4 | Byte lane enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_rdata | input | 32 | Read data from target, sampled while cfg_req is high |
| cfg_present | input | 1 | A target answered the current configuration cycle |

## Verification
The checker covers, on every cycle, the causal timing of cfg_req and cpu_ack relative to accepted requests. It also checks that memory-path cycles only follow in-window addresses, that device numbers never exceed 10 on the bus, that lane-enable counts agree with the size, that the index register only changes after a full-word write, and that absent-target reads return ones. The exact priority encoding, the cfg_addr and lane values, data shifting and masking, the index enable and bus-number gating, and back-to-back sequencing are shown only by the bench's stimulus vectors and directed sequences.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

  // What the front stage decided to do with an accepted request
  typedef enum logic [1:0] {
    ACT_FWD  = 2'd0,  // forward as a configuration cycle
    ACT_ONES = 2'd1,  // no target: reads give all ones, writes vanish
    ACT_IDX  = 2'd2,  // return the captured index register value
    ACT_NIL  = 2'd3   // unused
  } act_e;

  // Data mask for a size code: 0 -> byte, 1 -> half word, 2/3 -> word
  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    logic [31:0] m;
    if (sz[1])      m = 32'hFFFF_FFFF;
    else if (sz[0]) m = 32'h0000_FFFF;
    else            m = 32'h0000_00FF;
    return m;
  endfunction

endpackage

// File: rtl/cfgw_rst_sync.sv
module cfgw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/cfgw_sel_encoder.sv
// Lowest-set-bit priority encoder over the one-hot select lines.
module cfgw_sel_encoder #(
  parameter int SEL_BITS = 11,
  parameter int DEV_W    = 4
) (
  input  logic [SEL_BITS-1:0] sel,
  output logic [DEV_W-1:0]    dev,
  output logic                none
);
  logic [SEL_BITS-1:0] first;

  for (genvar g = 0; g < SEL_BITS; g++) begin : g_first
    if (g == 0) begin : g_lsb
      assign first[g] = sel[g];
    end else begin : g_upper
      assign first[g] = sel[g] & ~(|sel[g-1:0]);
    end
  end

  always_comb begin
    dev  = '0;
    none = ~(|sel);
    for (int i = 0; i < SEL_BITS; i++) begin
      if (first[i]) dev = dev | DEV_W'(i);
    end
    if (none) dev = DEV_W'(SEL_BITS);
  end
endmodule

// File: rtl/cfgw_lane_map.sv
// Size and low address bits to byte lanes, lane offset and aligned write data.
module cfgw_lane_map
  import cfgw_pkg::*;
(
  input  logic [1:0]  size,
  input  logic [1:0]  addr_lo,
  input  logic [31:0] wdata,
  output logic [3:0]  be,
  output logic [1:0]  off,
  output logic [31:0] wdata_lane
);
  always_comb begin
    if (size[1])      off = 2'd0;
    else if (size[0]) off = {addr_lo[1], 1'b0};
    else              off = addr_lo;

    if (size[1])      be = 4'hF;
    else if (size[0]) be = 4'b0011 << off;
    else              be = 4'b0001 << off;

    wdata_lane = (wdata & size_mask(size)) << {off, 3'b000};
  end
endmodule

// File: rtl/cfgw_index_reg.sv
module cfgw_index_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] q
);
  logic [31:0] q_d;

  always_comb q_d = wr_en ? wdata : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/cfgw_read_return.sv
// Forms the right-justified completion data for the back stage.
module cfgw_read_return
  import cfgw_pkg::*;
(
  input  act_e        act,
  input  logic        we,
  input  logic        present,
  input  logic [31:0] cfg_rdata,
  input  logic [31:0] held,
  input  logic [1:0]  off,
  input  logic [1:0]  size,
  output logic [31:0] rdata
);
  logic [31:0] raw;

  always_comb begin
    unique case (act)
      ACT_FWD: raw = present ? cfg_rdata : 32'hFFFF_FFFF;
      ACT_IDX: raw = held;
      default: raw = 32'hFFFF_FFFF;
    endcase
    rdata = we ? 32'h0 : ((raw >> {off, 3'b000}) & size_mask(size));
  end
endmodule

// File: rtl/cfg_window_bridge.sv
module cfg_window_bridge
  import cfgw_pkg::*;
#(
  parameter logic [31:0] WIN_BASE = 32'h8080_0000,
  parameter int          WIN_LOG2 = 22,
  parameter int          SEL_LSB  = 11,
  parameter int          SEL_BITS = 11,
  parameter logic [31:0] IO_INDEX = 32'h0000_0CF8,
  parameter logic [31:0] IO_DATA  = 32'h0000_0CFC,
  parameter int          CFG_AW   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_io,
  input  logic              cpu_we,
  input  logic [31:0]       cpu_addr,
  input  logic [1:0]        cpu_size,
  input  logic [31:0]       cpu_wdata,
  output logic              cpu_ack,
  output logic [31:0]       cpu_rdata,
  output logic              cfg_req,
  output logic              cfg_we,
  output logic [CFG_AW-1:0] cfg_addr,
  output logic [3:0]        cfg_be,
  output logic [31:0]       cfg_wdata,
  input  logic [31:0]       cfg_rdata,
  input  logic              cfg_present
);
  localparam int DEV_W = $clog2(SEL_BITS + 1);

  logic srst_n;
  cfgw_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  // ---------------- decode ----------------
  logic [SEL_BITS-1:0] sel_lines;
  logic [DEV_W-1:0]    dev_num;
  logic                no_sel;
  logic [3:0]          lane_be;
  logic [1:0]          lane_off;
  logic [31:0]         lane_wdata;
  logic [31:0]         idx_q;

  assign sel_lines = cpu_addr[SEL_LSB +: SEL_BITS];

  cfgw_sel_encoder #(.SEL_BITS(SEL_BITS), .DEV_W(DEV_W)) i_enc (
    .sel(sel_lines), .dev(dev_num), .none(no_sel)
  );

  cfgw_lane_map i_lane (
    .size(cpu_size), .addr_lo(cpu_addr[1:0]), .wdata(cpu_wdata),
    .be(lane_be), .off(lane_off), .wdata_lane(lane_wdata)
  );

  logic win_hit, idx_hit, dat_hit, full_word, idx_wr, path_on;
  logic              d_claim;
  act_e              d_act;
  logic [CFG_AW-1:0] d_addr;
  logic [31:0]       d_data;

  always_comb begin
    win_hit   = !cpu_io && (cpu_addr[31:WIN_LOG2] == WIN_BASE[31:WIN_LOG2]);
    idx_hit   = cpu_io && (cpu_addr[31:2] == IO_INDEX[31:2]);
    dat_hit   = cpu_io && (cpu_addr[31:2] == IO_DATA[31:2]);
    full_word = cpu_size[1];
    idx_wr    = cpu_req && idx_hit && cpu_we && full_word;
    path_on   = idx_q[31] && (idx_q[23:16] == 8'h00);
    d_claim   = win_hit || idx_hit || dat_hit;
    d_data    = lane_wdata;
    if (win_hit) begin
      d_act  = no_sel ? ACT_ONES : ACT_FWD;
      d_addr = (CFG_AW'(dev_num) << SEL_LSB) | CFG_AW'(cpu_addr[SEL_LSB-1:0]);
    end else if (dat_hit) begin
      d_act  = path_on ? ACT_FWD : ACT_ONES;
      d_addr = {idx_q[CFG_AW-1:2], cpu_addr[1:0]};
    end else begin
      d_act  = (!cpu_we && full_word) ? ACT_IDX : ACT_ONES;
      d_addr = '0;
      d_data = idx_q;
    end
  end

  cfgw_index_reg i_idx (
    .clk(clk), .rst_n(srst_n), .wr_en(idx_wr), .wdata(cpu_wdata), .q(idx_q)
  );

  // ---------------- front stage: configuration request ----------------
  logic              a_vld_q, a_vld_d;
  act_e              a_act_q, a_act_d;
  logic              a_we_q, a_we_d;
  logic [CFG_AW-1:0] a_addr_q, a_addr_d;
  logic [3:0]        a_be_q, a_be_d;
  logic [1:0]        a_off_q, a_off_d;
  logic [1:0]        a_size_q, a_size_d;
  logic [31:0]       a_data_q, a_data_d;
  logic              a_load;

  always_comb begin
    a_load   = cpu_req && d_claim;
    a_vld_d  = a_load;
    a_act_d  = a_load ? d_act     : a_act_q;
    a_we_d   = a_load ? cpu_we    : a_we_q;
    a_addr_d = a_load ? d_addr    : a_addr_q;
    a_be_d   = a_load ? lane_be   : a_be_q;
    a_off_d  = a_load ? lane_off  : a_off_q;
    a_size_d = a_load ? cpu_size  : a_size_q;
    a_data_d = a_load ? d_data    : a_data_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      a_vld_q  <= 1'b0;
      a_act_q  <= ACT_ONES;
      a_we_q   <= 1'b0;
      a_addr_q <= '0;
      a_be_q   <= '0;
      a_off_q  <= '0;
      a_size_q <= '0;
      a_data_q <= '0;
    end else begin
      a_vld_q  <= a_vld_d;
      a_act_q  <= a_act_d;
      a_we_q   <= a_we_d;
      a_addr_q <= a_addr_d;
      a_be_q   <= a_be_d;
      a_off_q  <= a_off_d;
      a_size_q <= a_size_d;
      a_data_q <= a_data_d;
    end
  end

  assign cfg_req   = a_vld_q && (a_act_q == ACT_FWD);
  assign cfg_we    = a_we_q;
  assign cfg_addr  = a_addr_q;
  assign cfg_be    = a_be_q;
  assign cfg_wdata = a_data_q;

  // ---------------- back stage: completion ----------------
  logic [31:0] ret_data;
  logic        b_vld_q, b_vld_d;
  logic [31:0] b_data_q, b_data_d;

  cfgw_read_return i_ret (
    .act(a_act_q), .we(a_we_q), .present(cfg_present), .cfg_rdata(cfg_rdata),
    .held(a_data_q), .off(a_off_q), .size(a_size_q), .rdata(ret_data)
  );

  always_comb begin
    b_vld_d  = a_vld_q;
    b_data_d = a_vld_q ? ret_data : b_data_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      b_vld_q  <= 1'b0;
      b_data_q <= '0;
    end else begin
      b_vld_q  <= b_vld_d;
      b_data_q <= b_data_d;
    end
  end

  assign cpu_ack   = b_vld_q;
  assign cpu_rdata = b_data_q;
endmodule

// File: rtl/cfg_window_bridge_chk.sv
module cfg_window_bridge_chk #(
  parameter logic [31:0] WIN_BASE = 32'h8080_0000,
  parameter int          WIN_LOG2 = 22,
  parameter int          SEL_LSB  = 11,
  parameter int          SEL_BITS = 11,
  parameter logic [31:0] IO_INDEX = 32'h0000_0CF8,
  parameter int          CFG_AW   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_io,
  input logic              cpu_we,
  input logic [31:0]       cpu_addr,
  input logic [1:0]        cpu_size,
  input logic              cpu_ack,
  input logic [31:0]       cpu_rdata,
  input logic              cfg_req,
  input logic              cfg_we,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [3:0]        cfg_be,
  input logic              cfg_present,
  input logic [31:0]       idx_q
);
  p_req_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> $past(cpu_req));

  p_ack_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> $past(cpu_req, 2));

  p_we_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (cfg_we == $past(cpu_we)));

  p_mem_in_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !$past(cpu_io)) |->
      ($past(cpu_addr[31:WIN_LOG2]) == WIN_BASE[31:WIN_LOG2]));

  p_dev_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !$past(cpu_io)) |-> (int'(cfg_addr[CFG_AW-1:SEL_LSB]) < SEL_BITS));

  p_be_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> ($countones(cfg_be) == 1 || $countones(cfg_be) == 2 ||
                 $countones(cfg_be) == 4));

  p_byte_be_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && $past(cpu_size) == 2'd0) |-> ($countones(cfg_be) == 1));

  p_absent_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && $past(cfg_req && !cfg_present && !cfg_we)) |->
      (cpu_rdata[7:0] == 8'hFF));

  p_idx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cpu_req && cpu_io && cpu_we && cpu_size[1] &&
           cpu_addr[31:2] == IO_INDEX[31:2]) |-> $stable(idx_q));

  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_n |-> (!cfg_req && !cpu_ack && idx_q == 32'h0));
endmodule

bind cfg_window_bridge cfg_window_bridge_chk #(
  .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2), .SEL_LSB(SEL_LSB),
  .SEL_BITS(SEL_BITS), .IO_INDEX(IO_INDEX), .CFG_AW(CFG_AW)
) i_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_io(cpu_io),
  .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
  .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata), .cfg_req(cfg_req),
  .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
  .cfg_present(cfg_present), .idx_q(idx_q)
);

// File: tb/test_cfg_window_bridge.sv
module test_cfg_window_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        cpu_req = 1'b0, cpu_io = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [1:0]  cpu_size = '0;
  logic        cpu_ack;
  logic [31:0] cpu_rdata;
  logic        cfg_req, cfg_we;
  logic [15:0] cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata = '0;
  logic        cfg_present = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cfg_window_bridge i_cfg_window_bridge (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_io(cpu_io),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
    .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_present(cfg_present)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic        io;
    logic        we;
    logic [31:0] addr;
    logic [1:0]  sz;
    logic [31:0] wd;
    logic        pres;
    logic [31:0] crd;
    logic        xreq;
    logic [15:0] xaddr;
    logic [3:0]  xbe;
    logic [31:0] xwd;
    logic        xack;
    logic [31:0] xrd;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    // R2: bit 11 -> device 0
    '{1'b0,1'b0,32'h8080_0800,2'd2,32'h0,1'b1,32'h4433_2211,1'b1,16'h0000,4'hF,32'h0,1'b1,32'h4433_2211},
    // R2: bit 12 -> device 1, register 0x10
    '{1'b0,1'b0,32'h8080_1010,2'd3,32'h0,1'b1,32'h4433_2211,1'b1,16'h0810,4'hF,32'h0,1'b1,32'h4433_2211},
    // R2, R4: bits 11,12,21 set -> device 0; byte at lane 3
    '{1'b0,1'b0,32'h80A0_1803,2'd0,32'h0,1'b1,32'h4433_2211,1'b1,16'h0003,4'h8,32'h0,1'b1,32'h0000_0044},
    // R2, R4: bit 21 -> device 10; half word at lane 2
    '{1'b0,1'b0,32'h80A0_0002,2'd1,32'h0,1'b1,32'h4433_2211,1'b1,16'h5002,4'hC,32'h0,1'b1,32'h0000_4433},
    // R3: no select bit -> device 11, all ones
    '{1'b0,1'b0,32'h8080_0044,2'd2,32'h0,1'b1,32'h4433_2211,1'b0,16'h0000,4'h0,32'h0,1'b1,32'hFFFF_FFFF},
    // R5: absent target read
    '{1'b0,1'b0,32'h8080_4000,2'd2,32'h0,1'b0,32'h4433_2211,1'b1,16'h1800,4'hF,32'h0,1'b1,32'hFFFF_FFFF},
    // R4: byte write lane 1, device 4
    '{1'b0,1'b1,32'h8080_8001,2'd0,32'hFFFF_FFAB,1'b1,32'h0,1'b1,16'h2001,4'h2,32'h0000_AB00,1'b1,32'h0},
    // R1: just above the window
    '{1'b0,1'b0,32'h80C0_0800,2'd2,32'h0,1'b1,32'h0,1'b0,16'h0,4'h0,32'h0,1'b0,32'h0},
    // R1: just below the window
    '{1'b0,1'b0,32'h807F_F800,2'd2,32'h0,1'b1,32'h0,1'b0,16'h0,4'h0,32'h0,1'b0,32'h0},
    // R6: write index, enabled, device 5, register 0x10
    '{1'b1,1'b1,32'h0000_0CF8,2'd2,32'h8000_2810,1'b1,32'h0,1'b0,16'h0,4'h0,32'h0,1'b1,32'h0},
    // R6: read index back
    '{1'b1,1'b0,32'h0000_0CF8,2'd2,32'h0,1'b1,32'h0,1'b0,16'h0,4'h0,32'h0,1'b1,32'h8000_2810},
    // R7: data port word read
    '{1'b1,1'b0,32'h0000_0CFC,2'd2,32'h0,1'b1,32'h4433_2211,1'b1,16'h2810,4'hF,32'h0,1'b1,32'h4433_2211},
    // R7, R4: data port half word at lane 2
    '{1'b1,1'b0,32'h0000_0CFE,2'd1,32'h0,1'b1,32'h4433_2211,1'b1,16'h2812,4'hC,32'h0,1'b1,32'h0000_4433},
    // R7, R4: data port byte write lane 1
    '{1'b1,1'b1,32'h0000_0CFD,2'd0,32'h0000_005A,1'b1,32'h0,1'b1,16'h2811,4'h2,32'h0000_5A00,1'b1,32'h0},
    // R6: half-word write to index is ignored
    '{1'b1,1'b1,32'h0000_0CF8,2'd1,32'h0000_0000,1'b1,32'h0,1'b0,16'h0,4'h0,32'h0,1'b1,32'h0},
    // R6: index unchanged
    '{1'b1,1'b0,32'h0000_0CF8,2'd2,32'h0,1'b1,32'h0,1'b0,16'h0,4'h0,32'h0,1'b1,32'h8000_2810},
    // R7: clear enable bit
    '{1'b1,1'b1,32'h0000_0CF8,2'd2,32'h0000_2810,1'b1,32'h0,1'b0,16'h0,4'h0,32'h0,1'b1,32'h0},
    // R7: disabled read -> ones, no cycle
    '{1'b1,1'b0,32'h0000_0CFC,2'd2,32'h0,1'b1,32'h4433_2211,1'b0,16'h0,4'h0,32'h0,1'b1,32'hFFFF_FFFF},
    // R7: disabled write dropped
    '{1'b1,1'b1,32'h0000_0CFC,2'd2,32'h0000_0011,1'b1,32'h0,1'b0,16'h0,4'h0,32'h0,1'b1,32'h0},
    // R7: enabled, bus 1
    '{1'b1,1'b1,32'h0000_0CF8,2'd2,32'h8001_2810,1'b1,32'h0,1'b0,16'h0,4'h0,32'h0,1'b1,32'h0},
    // R7: non-zero bus -> ones
    '{1'b1,1'b0,32'h0000_0CFC,2'd2,32'h0,1'b1,32'h4433_2211,1'b0,16'h0,4'h0,32'h0,1'b1,32'hFFFF_FFFF},
    // R1: other I/O port not claimed
    '{1'b1,1'b0,32'h0000_0CF0,2'd2,32'h0,1'b1,32'h0,1'b0,16'h0,4'h0,32'h0,1'b0,32'h0},
    // R1: index address in memory space not claimed
    '{1'b0,1'b0,32'h0000_0CF8,2'd2,32'h0,1'b1,32'h0,1'b0,16'h0,4'h0,32'h0,1'b0,32'h0},
    // R5, R4: absent target byte read -> 0xFF
    '{1'b0,1'b0,32'h8080_0801,2'd0,32'h0,1'b0,32'h4433_2211,1'b1,16'h0001,4'h2,32'h0,1'b1,32'h0000_00FF},
    // R3: device 11 half word -> 0xFFFF
    '{1'b0,1'b0,32'h8080_0046,2'd1,32'h0,1'b1,32'h4433_2211,1'b0,16'h0,4'h0,32'h0,1'b1,32'h0000_FFFF},
    // R2: top of window, all select bits -> device 0, register 0x7FC
    '{1'b0,1'b0,32'h80BF_FFFC,2'd2,32'h0,1'b1,32'h4433_2211,1'b1,16'h07FC,4'hF,32'h0,1'b1,32'h4433_2211}
  };

  task automatic drive(input logic io, input logic we, input logic [31:0] addr,
                       input logic [1:0] sz, input logic [31:0] wd);
    cpu_req = 1'b1; cpu_io = io; cpu_we = we;
    cpu_addr = addr; cpu_size = sz; cpu_wdata = wd;
  endtask

  task automatic idle();
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    chk("R9 cfg_req in reset", {31'b0, cfg_req}, 32'h0);
    chk("R9 cpu_ack in reset", {31'b0, cpu_ack}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // R9, R6: index reads 0 after reset
  task automatic check_index_zero();
    @(negedge clk);
    drive(1'b1, 1'b0, 32'h0000_0CF8, 2'd2, 32'h0);
    @(negedge clk);
    idle();
    @(negedge clk);
    chk("R9 ack after reset read", {31'b0, cpu_ack}, 32'h1);
    chk("R9 index after reset", cpu_rdata, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 cfg_req in reset", {31'b0, cfg_req}, 32'h0);
    chk("R9 cpu_ack in reset", {31'b0, cpu_ack}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_index_zero();

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      drive(VEC[v].io, VEC[v].we, VEC[v].addr, VEC[v].sz, VEC[v].wd);
      cfg_rdata   = VEC[v].crd;
      cfg_present = VEC[v].pres;
      @(negedge clk);
      idle();
      chk($sformatf("R1/R8 cfg_req vec %0d", v), {31'b0, cfg_req}, {31'b0, VEC[v].xreq});
      if (VEC[v].xreq) begin
        chk($sformatf("R2 cfg_addr vec %0d", v), {16'b0, cfg_addr}, {16'b0, VEC[v].xaddr});
        chk($sformatf("R4 cfg_be vec %0d", v), {28'b0, cfg_be}, {28'b0, VEC[v].xbe});
        chk($sformatf("R4 cfg_we vec %0d", v), {31'b0, cfg_we}, {31'b0, VEC[v].we});
        if (VEC[v].we)
          chk($sformatf("R4 cfg_wdata vec %0d", v), cfg_wdata, VEC[v].xwd);
      end
      @(negedge clk);
      chk($sformatf("R1/R8 cpu_ack vec %0d", v), {31'b0, cpu_ack}, {31'b0, VEC[v].xack});
      if (VEC[v].xack)
        chk($sformatf("R4 cpu_rdata vec %0d", v), cpu_rdata, VEC[v].xrd);
    end

    // R8: back-to-back requests, forwarded then device 11
    @(negedge clk);
    cfg_rdata = 32'h1122_3344; cfg_present = 1'b1;
    drive(1'b0, 1'b0, 32'h8080_0800, 2'd2, 32'h0);
    @(negedge clk);
    chk("R8 cfg_req first of pair", {31'b0, cfg_req}, 32'h1);
    drive(1'b0, 1'b0, 32'h8080_0044, 2'd2, 32'h0);
    @(negedge clk);
    idle();
    chk("R8 cfg_req second of pair (R3)", {31'b0, cfg_req}, 32'h0);
    chk("R8 ack first of pair", {31'b0, cpu_ack}, 32'h1);
    chk("R8 rdata first of pair", cpu_rdata, 32'h1122_3344);
    @(negedge clk);
    chk("R8 ack second of pair", {31'b0, cpu_ack}, 32'h1);
    chk("R8 rdata second of pair", cpu_rdata, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R8 ack is a single pulse", {31'b0, cpu_ack}, 32'h0);

    // R9: reset in mid-run clears the index register
    @(negedge clk);
    drive(1'b1, 1'b1, 32'h0000_0CF8, 2'd2, 32'h8000_0800);
    @(negedge clk);
    idle();
    repeat (2) @(negedge clk);
    do_reset();
    check_index_zero();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule